// File: doc/BRIEF.md
# Demand-Driven Three-Approach Intersection Arbiter

This block controls the green signals of a T-shaped crossing with a north, a south and an east approach. Each approach has a one-bit vehicle sensor and a one-bit green output. A sensor pulse leaves a pending request behind, so a car that has rolled off the loop is still served. North and south are compatible movements and may run green together. East conflicts with both, so it never shows green while either of them does.

The controller runs on demand. It has no fixed cycle and no timers. A green starts when its request is pending and the conflicting side is idle. It stays on for as long as the sensor of that approach is high, and it drops on the clock after the sensor goes low. A lock flag marks that the north/south side owns the crossing. A turn flag decides which side wins when both sides wait at the same time, so a busy side cannot starve the other. All state is cleared by a synchronous, active-high reset.

Top module: `xing_arbiter`

## Requirements
- R1: While reset is high at a rising edge, every green, every pending request, the north/south lock and the turn flag are cleared after that edge. The cleared turn flag favours the north/south side.
- R2: A sensor that is high before a rising edge leaves that approach with a pending request after the edge. A single-cycle pulse on an idle crossing therefore gives green on the second edge after the pulse.
- R3: East green is set at the next edge when all of these hold: an east request is pending, the lock is clear, no green is on, and either it is east's turn or no north/south request is pending.
- R4: North (and likewise south) green is set at the next edge when its request is pending, it is not already green, east is not green, east is not being granted, and no east request is pending while it is east's turn. Such a grant sets the lock and hands the turn to east.
- R5: North and south requests that are both pending are granted together, and both greens may be on in the same cycle.
- R6: East green is never high in the same cycle as north green or south green.
- R7: A green that is on stays on at the next edge while the sensor of its approach is high.
- R8: A green that is on while its sensor is low is cleared at the next edge, together with that approach's request. No further green follows until the sensor rises again.
- R9: The lock clears at an edge where no north/south green is on and either no north/south request is pending or an east request is pending on east's turn. East therefore turns green no earlier than the second edge after the last north/south green went off.
- R10: When both sides wait with nothing green, the side that was not served last wins. An east grant hands the turn back to north/south.
- R11: If every sensor stays high for at most 8 cycles at a time, every sensor assertion on a red approach is followed by green on that approach within 40 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sens_n | input | 1 | North vehicle sensor |
| sens_s | input | 1 | South vehicle sensor |
| sens_e | input | 1 | East vehicle sensor |
| grn_n | output | 1 | North green |
| grn_s | output | 1 | South green |
| grn_e | output | 1 | East green |

## Verification
The bench targets the edges where the two sides hand the crossing over. One case has an east car arriving while a north green is held: a design that released the lock too early would light east one cycle after north went dark, or even while north was still green. A second case has simultaneous north and east arrivals, both right after reset and after a north-only service. A broken turn flag would serve the same side twice, or starve east under steady north/south traffic, and the 40-cycle service bound would catch that in the random phase. The bench also checks one-cycle sensor pulses: a design that does not latch the request would never light green, and one that does not clear the request would light green a second time.

// File: rtl/xing_pkg.sv
package xing_pkg;
    localparam int unsigned NUM_LANES = 3;
    localparam int unsigned LANE_N    = 0;
    localparam int unsigned LANE_S    = 1;
    localparam int unsigned LANE_E    = 2;

    typedef struct packed {
        logic req;
        logic grn;
    } lane_state_t;

    typedef struct packed {
        logic pair_lock;
        logic east_turn;
    } arb_state_t;
endpackage

// File: rtl/xing_lane.sv
module xing_lane
    import xing_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sens,
    input  logic go,
    output logic req,
    output logic grn
);
    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.grn && !sens) begin
            st_d.grn = 1'b0;
            st_d.req = 1'b0;
        end
        if (go) begin
            st_d.grn = 1'b1;
        end
        if (sens) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;
    assign grn = st_q.grn;

    assert_latch_R2: assert property (@(posedge clk) disable iff (rst)
        sens |=> req);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (grn && sens) |=> grn);

    assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (grn && !sens) |=> (!grn && !req));
endmodule

// File: rtl/xing_grant.sv
module xing_grant
    import xing_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] req,
    input  logic [NUM_LANES-1:0] grn,
    output logic [NUM_LANES-1:0] go
);
    arb_state_t st_d, st_q;

    logic ns_want;
    logic ns_busy;
    logic east_claim;
    logic east_go;
    logic ns_open;

    always_comb begin
        st_d       = st_q;
        ns_want    = req[LANE_N] | req[LANE_S];
        ns_busy    = grn[LANE_N] | grn[LANE_S];
        east_claim = req[LANE_E] & st_q.east_turn;

        east_go = req[LANE_E] & ~st_q.pair_lock & ~grn[LANE_E] & ~ns_busy
                & (st_q.east_turn | ~ns_want);
        ns_open = ~grn[LANE_E] & ~east_go & ~east_claim;

        go           = '0;
        go[LANE_E]   = east_go;
        go[LANE_N]   = req[LANE_N] & ~grn[LANE_N] & ns_open;
        go[LANE_S]   = req[LANE_S] & ~grn[LANE_S] & ns_open;

        if (!ns_busy && (!ns_want || east_claim)) begin
            st_d.pair_lock = 1'b0;
        end
        if (go[LANE_N] || go[LANE_S]) begin
            st_d.pair_lock = 1'b1;
            st_d.east_turn = 1'b1;
        end
        if (east_go) begin
            st_d.east_turn = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_one_side_R6: assert property (@(posedge clk) disable iff (rst)
        !(go[LANE_E] && (go[LANE_N] || go[LANE_S])));

    assert_lock_covers_pair_R9: assert property (@(posedge clk) disable iff (rst)
        (grn[LANE_N] || grn[LANE_S]) |-> st_q.pair_lock);

    assert_east_hands_back_R10: assert property (@(posedge clk) disable iff (rst)
        go[LANE_E] |=> !st_q.east_turn);
endmodule

// File: rtl/xing_arbiter.sv
module xing_arbiter
    import xing_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sens_n,
    input  logic sens_s,
    input  logic sens_e,
    output logic grn_n,
    output logic grn_s,
    output logic grn_e
);
    logic [NUM_LANES-1:0] sens_v;
    logic [NUM_LANES-1:0] req_v;
    logic [NUM_LANES-1:0] grn_v;
    logic [NUM_LANES-1:0] go_v;

    always_comb begin
        sens_v         = '0;
        sens_v[LANE_N] = sens_n;
        sens_v[LANE_S] = sens_s;
        sens_v[LANE_E] = sens_e;
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        xing_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .sens (sens_v[i]),
            .go   (go_v[i]),
            .req  (req_v[i]),
            .grn  (grn_v[i])
        );
    end

    xing_grant u_grant (
        .clk (clk),
        .rst (rst),
        .req (req_v),
        .grn (grn_v),
        .go  (go_v)
    );

    assign grn_n = grn_v[LANE_N];
    assign grn_s = grn_v[LANE_S];
    assign grn_e = grn_v[LANE_E];

    assert_safe_R6: assert property (@(posedge clk) disable iff (rst)
        !(grn_e && (grn_n || grn_s)));

    assert_east_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(grn_e) |-> (!$past(grn_n) && !$past(grn_s)));

    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (!grn_n && !grn_s && !grn_e));
endmodule

// File: tb/test_xing_arbiter.sv
`timescale 1ns/1ps
module test_xing_arbiter;
    localparam int BOUND    = 40;
    localparam int HOLD_MAX = 8;
    localparam int RAND_CYC = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] sens = 3'b000;   // bit0 north, bit1 south, bit2 east
    logic [2:0] g_now = 3'b000;
    logic grn_n, grn_s, grn_e;

    int n_chk  = 0;
    int n_fail = 0;
    bit waiting [3];
    int wait_cnt [3];

    always #2.5 clk = ~clk;

    xing_arbiter i_xing_arbiter (
        .clk    (clk),
        .rst    (rst),
        .sens_n (sens[0]),
        .sens_s (sens[1]),
        .sens_e (sens[2]),
        .grn_n  (grn_n),
        .grn_s  (grn_s),
        .grn_e  (grn_e)
    );

    function automatic bit safe_ok(input logic [2:0] g);
        return !(g[2] && (g[0] || g[1]));
    endfunction

    function automatic logic exp_next_grn(input logic prev_g, input logic s);
        return s;   // only meaningful when prev_g is high
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [2:0] act,
                       input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic step();
        logic [2:0] pg;
        logic [2:0] ap;
        logic was_rst;
        pg = g_now;
        ap = sens;
        was_rst = rst;
        for (int i = 0; i < 3; i++) begin
            if (!was_rst && ap[i] && !pg[i] && !waiting[i]) begin
                waiting[i] = 1'b1;
                wait_cnt[i] = 0;
            end
        end
        @(posedge clk);
        #1;
        g_now = {grn_e, grn_s, grn_n};
        if (!was_rst) begin
            chk(safe_ok(g_now), "R6", g_now, {1'b0, g_now[1:0]});
            for (int i = 0; i < 3; i++) begin
                if (pg[i]) begin
                    chk(g_now[i] == exp_next_grn(pg[i], ap[i]),
                        ap[i] ? "R7" : "R8", {2'b0, g_now[i]}, {2'b0, ap[i]});
                end
                if (waiting[i]) begin
                    if (g_now[i]) begin
                        chk(wait_cnt[i] <= BOUND, "R11", 3'(i), 3'(i));
                        waiting[i] = 1'b0;
                    end else begin
                        wait_cnt[i]++;
                        if (wait_cnt[i] > BOUND) begin
                            chk(1'b0, "R11", 3'b000, 3'(1 << i));
                            waiting[i] = 1'b0;
                        end
                    end
                end
            end
        end
    endtask

    task automatic expect_g(input logic [2:0] exp, input string tag);
        chk(g_now == exp, tag, g_now, exp);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        sens = 3'b000;
        for (int i = 0; i < 3; i++) begin
            waiting[i] = 1'b0;
            wait_cnt[i] = 0;
        end
        repeat (3) step();
        expect_g(3'b000, "R1");
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 3'b000, 3'b111);
        summary();
        $finish;
    end

    initial begin
        int hi_left [3];
        int lo_left [3];
        void'($urandom(32'd20240611));

        do_reset();
        step(); expect_g(3'b000, "R1");

        // East pulse alone: request only, then one-cycle green, then dark
        sens = 3'b100; step(); expect_g(3'b000, "R2");
        sens = 3'b000; step(); expect_g(3'b100, "R3");
        step(); expect_g(3'b000, "R8");
        repeat (3) begin step(); expect_g(3'b000, "R8"); end

        // North and south together, held two cycles
        sens = 3'b011; step(); expect_g(3'b000, "R2");
        step(); expect_g(3'b011, "R5");
        step(); expect_g(3'b011, "R7");
        sens = 3'b000; step(); expect_g(3'b000, "R8");
        repeat (2) step();

        // North was served last: east wins the tie
        sens = 3'b101; step(); expect_g(3'b000, "R2");
        sens = 3'b000; step(); expect_g(3'b100, "R10");
        step(); expect_g(3'b000, "R10");
        step(); expect_g(3'b001, "R10");
        step(); expect_g(3'b000, "R8");
        repeat (2) step();

        // East arrives while north holds green: waits for lock release
        sens = 3'b001; step(); expect_g(3'b000, "R2");
        step(); expect_g(3'b001, "R4");
        sens = 3'b101; step(); expect_g(3'b001, "R7");
        sens = 3'b001; step(); expect_g(3'b001, "R9");
        step(); expect_g(3'b001, "R9");
        sens = 3'b000; step(); expect_g(3'b000, "R8");
        step(); expect_g(3'b000, "R9");
        step(); expect_g(3'b100, "R9");
        step(); expect_g(3'b000, "R8");

        // After reset the north/south side wins the tie
        do_reset();
        sens = 3'b101; step(); expect_g(3'b000, "R2");
        sens = 3'b000; step(); expect_g(3'b001, "R4");
        step(); expect_g(3'b000, "R8");
        step(); expect_g(3'b000, "R9");
        step(); expect_g(3'b100, "R3");
        step(); expect_g(3'b000, "R8");

        // Fair random traffic: each sensor high at most HOLD_MAX cycles
        do_reset();
        for (int i = 0; i < 3; i++) begin
            hi_left[i] = 0;
            lo_left[i] = int'($urandom_range(0, 6));
        end
        for (int c = 0; c < RAND_CYC; c++) begin
            logic [2:0] nx;
            nx = 3'b000;
            for (int i = 0; i < 3; i++) begin
                if (hi_left[i] == 0 && lo_left[i] == 0) begin
                    hi_left[i] = int'($urandom_range(1, HOLD_MAX));
                end
                if (hi_left[i] > 0) begin
                    nx[i] = 1'b1;
                    hi_left[i]--;
                    if (hi_left[i] == 0) lo_left[i] = int'($urandom_range(2, 14));
                end else begin
                    lo_left[i]--;
                end
            end
            sens = nx;
            step();
        end

        // Drain: every outstanding request must be served
        sens = 3'b000;
        repeat (BOUND + 10) step();
        for (int i = 0; i < 3; i++) begin
            chk(!waiting[i], "R11", 3'(waiting[i]), 3'b000);
        end
        expect_g(3'b000, "R8");

        summary();
        $finish;
    end
endmodule